// File: doc/BRIEF.md
# Hibernate Wake and Reset Sequencer

This block sits in an always-on power domain that runs from a 32 kHz tick clock. It controls whether the main supply is on, and it produces the reset for the logic behind that supply. Software writes a command word to put the system into hibernation. The block then drops the power-enable output and holds the system reset low.

While hibernating, the block watches an external wake pin. The pin is synchronised, and it must stay asserted for a programmed number of ticks before power returns, so short glitches cannot wake the system. When the count is met, power-enable rises while reset stays low for a second programmed number of ticks. Reset is then released and the block is back in its running state.

Both durations are programmed through coarse fields whose lowest five bits are dropped, so they step in units of 32 ticks. A write value that is larger than a field can hold is clamped to the field's maximum instead of wrapping.

Top module: `hib_wake_seq`

## Requirements
- R1: A write to address 0 with data bit 0 set, accepted in the running state, drives `pwr_en` and `sys_rst_n` low at the same rising edge that samples the write.
- R2: A write to address 0 with data bit 0 clear is ignored. A hibernate command that arrives while the block is not in the running state is also ignored.
- R3: The wake filter count is written at address 1. Only data bits 15:5 are kept (mask 0xFFE0), and all other bits of an in-range value are discarded.
- R4: The reset hold count is written at address 2. Only data bits 11:5 are kept (mask 0x0FE0), and all other bits of an in-range value are discarded.
- R5: A write value numerically above a field's mask sets that field to the full mask (0xFFE0 or 0x0FE0) rather than to its masked bits.
- R6: The wake pin passes through a two-flop synchroniser. Let N be the filter count and let the pin first be sampled high at edge 1. If the pin then stays high, `pwr_en` rises at edge N+3. With N=0, this is the first synchronised assertion.
- R7: If the synchronised pin drops before the count reaches N, the filter count is cleared and power stays off. A pin pulse lasting N sampled ticks or fewer causes no wake-up.
- R8: After `pwr_en` rises, `sys_rst_n` stays low for H+1 ticks, where H is the hold count, and then rises. `pwr_en` stays high throughout.
- R9: After reset, `pwr_en` and `sys_rst_n` are high and both count fields are zero.
- R10: `sys_rst_n` is low in every cycle in which `pwr_en` is low.
- R11: In the running state the wake pin has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 kHz tick clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 command, 1 wake filter, 2 reset hold |
| wr_data | input | 32 | Register write data |
| wake_pin | input | 1 | Asynchronous wake request, active high |
| pwr_en | output | 1 | Main supply enable, registered |
| sys_rst_n | output | 1 | Active-low system reset, registered |

## Verification
The hardest case to reach is a wake pulse that ends exactly one synchronised sample short of the programmed filter count. It must be followed by a full-length pulse, to show that the counter was cleared and did not carry the earlier progress forward. The bench holds the pin for exactly N clock periods, watches that power stays off, and then applies a long pulse whose timing is measured from its first sample. A hibernate command is also injected during the reset hold, and the bench checks that the release edge does not move.

// File: rtl/hib_pkg.sv
package hib_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_HIB   = 2'd1,
    ST_FILT  = 2'd2,
    ST_RHOLD = 2'd3
  } hib_state_e;
endpackage

// File: rtl/hib_sync.sv
module hib_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-2:0], din};
  end

  assign dout = sr[STAGES-1];
endmodule

// File: rtl/hib_regs.sv
module hib_regs #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2,
  parameter int CNT_W     = 16,
  parameter int FIELD_LSB = 5,
  parameter int FILT_MSB  = 15,
  parameter int HOLD_MSB  = 11,
  parameter logic [ADDR_W-1:0] ADDR_CMD  = 0,
  parameter logic [ADDR_W-1:0] ADDR_FILT = 1,
  parameter logic [ADDR_W-1:0] ADDR_HOLD = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hib_req,
  output logic [CNT_W-1:0]  filt_val,
  output logic [CNT_W-1:0]  hold_val
);
  function automatic logic [DATA_W-1:0] mk_mask(input int msb, input int lsb);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = lsb; i <= msb; i++) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] FILT_MASK = mk_mask(FILT_MSB, FIELD_LSB);
  localparam logic [DATA_W-1:0] HOLD_MASK = mk_mask(HOLD_MSB, FIELD_LSB);

  logic [DATA_W-1:0] filt_sat, hold_sat;

  // Clamp oversize values to the full field, otherwise keep the field bits
  always_comb begin
    filt_sat = (wr_data > FILT_MASK) ? FILT_MASK : (wr_data & FILT_MASK);
    hold_sat = (wr_data > HOLD_MASK) ? HOLD_MASK : (wr_data & HOLD_MASK);
  end

  assign hib_req = wr_en && (wr_addr == ADDR_CMD) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_val <= '0;
      hold_val <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_FILT) filt_val <= filt_sat[CNT_W-1:0];
      if (wr_addr == ADDR_HOLD) hold_val <= hold_sat[CNT_W-1:0];
    end
  end

  // R3: filter field never holds bits outside its mask
  p_filt_clean_r3: assert property (@(posedge clk) disable iff (rst)
    (filt_val & ~FILT_MASK[CNT_W-1:0]) == '0);
  // R4: hold field never holds bits outside its mask
  p_hold_clean_r4: assert property (@(posedge clk) disable iff (rst)
    (hold_val & ~HOLD_MASK[CNT_W-1:0]) == '0);
  // R5: an oversize write leaves the field at full mask
  p_sat_filt_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_FILT && wr_data > FILT_MASK)
      |=> (filt_val == FILT_MASK[CNT_W-1:0]));
endmodule

// File: rtl/hib_fsm.sv
module hib_fsm
  import hib_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hib_req,
  input  logic             wake_s,
  input  logic [CNT_W-1:0] filt_val,
  input  logic [CNT_W-1:0] hold_val,
  output logic             pwr_en,
  output logic             sys_rst_n
);
  hib_state_e st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    unique case (st)
      ST_RUN: begin
        cnt_n = '0;
        if (hib_req) st_n = ST_HIB;
      end
      ST_HIB: begin
        cnt_n = '0;
        if (wake_s) begin
          if (filt_val == '0) st_n = ST_RHOLD;
          else begin
            st_n  = ST_FILT;
            cnt_n = CNT_W'(1);
          end
        end
      end
      ST_FILT: begin
        if (!wake_s) begin
          st_n  = ST_HIB;
          cnt_n = '0;
        end else if (cnt >= filt_val) begin
          st_n  = ST_RHOLD;
          cnt_n = '0;
        end else begin
          cnt_n = cnt + CNT_W'(1);
        end
      end
      ST_RHOLD: begin
        if (cnt >= hold_val) begin
          st_n  = ST_RUN;
          cnt_n = '0;
        end else begin
          cnt_n = cnt + CNT_W'(1);
        end
      end
      default: begin
        st_n  = ST_RUN;
        cnt_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_RUN;
      cnt       <= '0;
      pwr_en    <= 1'b1;
      sys_rst_n <= 1'b1;
    end else begin
      st        <= st_n;
      cnt       <= cnt_n;
      pwr_en    <= (st_n == ST_RUN) || (st_n == ST_RHOLD);
      sys_rst_n <= (st_n == ST_RUN);
    end
  end

  // R1: accepted hibernate command removes power next cycle
  p_hib_entry_r1: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && hib_req) |=> (!pwr_en && !sys_rst_n));
  // R2: command outside the running state does not drop power in reset hold
  p_cmd_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RHOLD && hib_req) |=> pwr_en);
  // R6: power returns only after a synchronised pin sample
  p_wake_pin_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_en) |-> $past(wake_s));
  // R7: a drop of the pin during filtering returns to hibernation
  p_filt_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FILT && !wake_s) |=> (st == ST_HIB && !pwr_en));
  // R8: reset release only with power already on
  p_release_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_n) |-> (pwr_en && $past(pwr_en)));
  // R10: reset is held whenever power is off
  p_rst_with_pwr_r10: assert property (@(posedge clk) disable iff (rst)
    !pwr_en |-> !sys_rst_n);
  // R11: running state without command keeps both outputs high
  p_run_steady_r11: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && !hib_req) |=> (pwr_en && sys_rst_n));
endmodule

// File: rtl/hib_wake_seq.sv
module hib_wake_seq #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2,
  parameter int CNT_W     = 16,
  parameter int SYNC_LEN  = 2,
  parameter int FIELD_LSB = 5,
  parameter int FILT_MSB  = 15,
  parameter int HOLD_MSB  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wake_pin,
  output logic              pwr_en,
  output logic              sys_rst_n
);
  logic             hib_req;
  logic             wake_s;
  logic [CNT_W-1:0] filt_val, hold_val;

  hib_sync #(.STAGES(SYNC_LEN)) sync_i (
    .clk (clk),
    .rst (rst),
    .din (wake_pin),
    .dout(wake_s)
  );

  hib_regs #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .FIELD_LSB(FIELD_LSB),
    .FILT_MSB (FILT_MSB),
    .HOLD_MSB (HOLD_MSB)
  ) regs_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .hib_req (hib_req),
    .filt_val(filt_val),
    .hold_val(hold_val)
  );

  hib_fsm #(.CNT_W(CNT_W)) fsm_i (
    .clk      (clk),
    .rst      (rst),
    .hib_req  (hib_req),
    .wake_s   (wake_s),
    .filt_val (filt_val),
    .hold_val (hold_val),
    .pwr_en   (pwr_en),
    .sys_rst_n(sys_rst_n)
  );
endmodule

// File: tb/hib_wake_seq_tb.sv
`timescale 1ns/1ps
module hib_wake_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic        wake_pin;
  logic        pwr_en, sys_rst_n;

  int nvec = 0;
  int nerr = 0;
  int cyc  = 0;

  always #2.5 clk = ~clk;

  hib_wake_seq dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wake_pin(wake_pin), .pwr_en(pwr_en), .sys_rst_n(sys_rst_n)
  );

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 195000) begin
      nerr++;
      $display("FAIL watchdog: act=%0d cycles exp<=195000", cyc);
      report();
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int eff_filt(input logic [31:0] raw);
    return (raw > 32'hFFE0) ? 32'hFFE0 : int'(raw & 32'hFFE0);
  endfunction
  function automatic int eff_hold(input logic [31:0] raw);
    return (raw > 32'h0FE0) ? 32'h0FE0 : int'(raw & 32'h0FE0);
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic hibernate();
    wr(2'd0, 32'h1);
    chk(!pwr_en && !sys_rst_n, "R1 outputs low after command", {pwr_en, sys_rst_n}, 0);
    repeat (3) @(negedge clk);
    chk(!pwr_en && !sys_rst_n, "R10 reset low while off", {pwr_en, sys_rst_n}, 0);
  endtask

  // Raise the pin and time both output edges from the first sampling edge
  task automatic wake(input int n, input int h, input bit poke, input string tag);
    int k = 0, kp = -1, kr = -1;
    bit dropped = 0;
    wake_pin = 1'b1;
    while (kr < 0 && k < n + h + 30) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      wr_en = 1'b0;
      if (kp >= 0 && !pwr_en) dropped = 1;
      if (pwr_en && kp < 0) begin
        kp = k;
        if (poke) begin
          wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h1;
        end
      end
      if (!pwr_en && sys_rst_n) dropped = 1;
      if (sys_rst_n && kr < 0) kr = k;
    end
    wake_pin = 1'b0;
    chk(kp == n + 3, {"R6 power edge ", tag}, kp, n + 3);
    chk(kr == n + h + 4, {"R8 reset release ", tag}, kr, n + h + 4);
    chk(!dropped, {"R10 power held in hold ", tag}, dropped, 0);
    if (poke) chk(kr == n + h + 4, "R2 command in hold ignored", kr, n + h + 4);
    repeat (3) @(negedge clk);
    chk(pwr_en && sys_rst_n, {"R8 back to run ", tag}, {pwr_en, sys_rst_n}, 3);
  endtask

  initial begin
    int n, h;
    logic [31:0] rf, rh;
    bit bad;
    void'($urandom(32'd20240611));
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; wake_pin = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(pwr_en && sys_rst_n, "R9 reset state", {pwr_en, sys_rst_n}, 3);

    // R11: pin activity while running
    wake_pin = 1'b1;
    bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (!(pwr_en && sys_rst_n)) bad = 1;
    end
    wake_pin = 1'b0;
    chk(!bad, "R11 pin ignored in run", bad, 0);

    // R2: command words with bit 0 clear
    wr(2'd0, 32'h2);
    chk(pwr_en && sys_rst_n, "R2 bit0 clear ignored", {pwr_en, sys_rst_n}, 3);
    wr(2'd0, 32'h0);
    chk(pwr_en && sys_rst_n, "R2 zero ignored", {pwr_en, sys_rst_n}, 3);

    // R9: fields zero after reset -> immediate wake, one-tick hold
    hibernate();
    wake(0, 0, 1'b0, "R9 default fields");

    // R3/R4: low junk bits dropped
    wr(2'd1, 32'h0000_003F);
    wr(2'd2, 32'h0000_0A7B);
    hibernate();
    wake(eff_filt(32'h3F), eff_hold(32'hA7B), 1'b0, "R3 R4 field masking");

    // R7: glitch one sample short, then full wake
    wr(2'd2, 32'h0000_0040);
    hibernate();
    wake_pin = 1'b1;
    repeat (32) @(negedge clk);
    wake_pin = 1'b0;
    bad = 0;
    repeat (60) begin
      @(negedge clk);
      if (pwr_en) bad = 1;
    end
    chk(!bad, "R7 short pulse rejected", bad, 0);
    wake(32, 64, 1'b1, "R7 full pulse after glitch");

    // R5: saturation of both fields
    wr(2'd1, 32'h0001_0000);
    wr(2'd2, 32'hFFFF_FFFF);
    hibernate();
    wake(32'hFFE0, 32'h0FE0, 1'b0, "R5 saturation");

    // Random programming
    for (int i = 0; i < 6; i++) begin
      rf = $urandom % 32'h600;
      rh = $urandom % 32'h1000;
      n = eff_filt(rf);
      h = eff_hold(rh);
      wr(2'd1, rf);
      wr(2'd2, rh);
      hibernate();
      wake(n, h, i[0], "R6 random");
    end

    report();
  end
endmodule